// File: doc/BRIEF.md
# Dual-Buffer Serial Write Loader

This block is the receive side of a serial memory command port. It watches chip select, serial clock and serial data and turns them into byte writes for one of two on-chip page buffers. A command is one opcode byte that picks the buffer, then four address bytes, then any number of data bytes. Each data byte goes to the current buffer position. The position then advances and wraps at the end of the buffer. The command ends when chip select returns high.

The serial pins are oversampled by the system clock through synchronizers. Rising serial-clock edges are detected in that clock domain. At every chip-select fall the idle level of the serial clock is captured as the active serial mode (0 or 3), and that mode is reported on an output. Both buffers share one address and data bus and have separate write enables. A select flag shows which buffer the current command targets.

Top module: `dualbuf_spi_loader`

## Requirements
- R1: Opcode 0x84 targets buffer A (`buf_a_we_o`, `buf_sel_o` = 0) and opcode 0x87 targets buffer B (`buf_b_we_o`, `buf_sel_o` = 1). Every write pulse agrees with `buf_sel_o`.
- R2: The opcode is followed by four address bytes that form a 32-bit field, sent most significant byte first. Only bits 10..0 of that field set the start position; bits 31..11 have no effect.
- R3: A start value from 1056 to 2047 is reduced modulo 1056, so the first write lands at value - 1056.
- R4: Successive data bytes go to successive positions. After position 1055 the next byte goes to position 0 of the same buffer. `buf_addr_o` never exceeds 1055 while a write enable is high.
- R5: Bits are taken most significant first, on rising edges of `sck_i` while `cs_ni` is low. No bit is taken before the fall of `cs_ni`.
- R6: A rise of `cs_ni` ends the command. A partial byte of fewer than eight bits is dropped and never written. The next command starts bit and byte counting afresh.
- R7: Any opcode other than 0x84 or 0x87 causes no write until `cs_ni` rises, whatever bytes follow.
- R8: At each fall of `cs_ni`, `mode3_o` takes the level of `sck_i` (1 = mode 3, 0 = mode 0). `mode3_o` is 1 after reset.
- R9: While `rst_ni` is low, any command is aborted, no write enable is high, and `mode3_o` is 1. After release, no bytes are accepted until `cs_ni` has been seen to fall.
- R10: Each data byte produces exactly one write-enable pulse, one clock wide. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| buf_addr_o | output | 11 | Byte position for the current write |
| buf_data_o | output | 8 | Byte to write |
| buf_a_we_o | output | 1 | Write enable of buffer A |
| buf_b_we_o | output | 1 | Write enable of buffer B |
| buf_sel_o | output | 1 | Buffer targeted by the command (0 = A, 1 = B) |
| mode3_o | output | 1 | Serial mode captured at the last chip-select fall |

## Verification
The bench sweeps start fields across the whole 11-bit range in both modes and both buffers, with junk in the ignored upper bits. A design that used the wrong address bits, skipped the modulo step, or wrapped at 2048 instead of 1056 would write bytes to the wrong positions. It also runs commands that cross position 1055. It ends some commands with a partial byte and checks the next command; a design that kept stale bits would shift every later byte. Further cases cover unknown opcodes whose trailing bytes look like valid opcodes, and a reset applied in the middle of a command with chip select held low through the release. A design that did not re-arm on a chip-select fall would accept those bytes.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  typedef enum logic [1:0] {
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } cmd_st_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dbl_sync.sv
module dbl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= RST_VAL;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dbl_shift.sv
module dbl_shift import dbl_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              idle_o,
  output logic              mode3_o
);
  logic              cs_q, sck_q, armed_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              cs_fall, sck_rise;

  assign cs_fall  = cs_q & ~cs_n_i;
  assign sck_rise = sck_i & ~sck_q;
  assign idle_o   = cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      // cs_q resets low: a select already low at release is not a fall
      cs_q       <= 1'b0;
      sck_q      <= 1'b0;
      armed_q    <= 1'b0;
      bit_q      <= '0;
      sh_q       <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      mode3_o    <= 1'b1;
    end else begin
      cs_q       <= cs_n_i;
      sck_q      <= sck_i;
      byte_vld_o <= 1'b0;
      if (cs_n_i) begin
        armed_q <= 1'b0;
        bit_q   <= '0;
      end else if (cs_fall) begin
        armed_q <= 1'b1;
        bit_q   <= '0;
        mode3_o <= sck_i;
      end else if (armed_q && sck_rise) begin
        sh_q  <= {sh_q[BYTE_W-2:0], si_i};
        bit_q <= bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          byte_o     <= {sh_q[BYTE_W-2:0], si_i};
          byte_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbl_cmd.sv
module dbl_cmd import dbl_pkg::*; #(
  parameter int unsigned BUF_BYTES  = 1056,
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned ADDR_BYTES = 4,
  parameter logic [7:0]  OP_A       = 8'h84,
  parameter logic [7:0]  OP_B       = 8'h87
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              idle_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              we_a_o,
  output logic              we_b_o,
  output logic              sel_o
);
  localparam int unsigned CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [ADDR_W:0]   LEN_X    = (ADDR_W+1)'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] POS_LAST = ADDR_W'(BUF_BYTES - 1);

  cmd_st_e            st_q;
  logic               sel_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [ADDR_W+BYTE_W-1:0] cat;
  logic [ADDR_W-1:0]  start_nx, start_red;

  // ptr_q doubles as the start-field accumulator in ST_ADDR
  always_comb begin
    cat       = {ptr_q, byte_i};
    start_nx  = cat[ADDR_W-1:0];
    start_red = ({1'b0, start_nx} >= LEN_X) ? (start_nx - LEN_X[ADDR_W-1:0]) : start_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OPC;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      addr_o <= '0;
      data_o <= '0;
      we_a_o <= 1'b0;
      we_b_o <= 1'b0;
    end else begin
      we_a_o <= 1'b0;
      we_b_o <= 1'b0;
      if (byte_vld_i) begin
        unique case (st_q)
          ST_OPC: begin
            cnt_q <= '0;
            ptr_q <= '0;
            if (byte_i == OP_A) begin
              sel_q <= 1'b0;
              st_q  <= ST_ADDR;
            end else if (byte_i == OP_B) begin
              sel_q <= 1'b1;
              st_q  <= ST_ADDR;
            end else begin
              st_q  <= ST_SKIP;
            end
          end
          ST_ADDR: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              ptr_q <= start_red;
              st_q  <= ST_DATA;
            end else begin
              ptr_q <= start_nx;
            end
          end
          ST_DATA: begin
            addr_o <= ptr_q;
            data_o <= byte_i;
            we_a_o <= ~sel_q;
            we_b_o <= sel_q;
            ptr_q  <= (ptr_q == POS_LAST) ? '0 : ptr_q + 1'b1;
          end
          default: ;
        endcase
      end else if (idle_i) begin
        st_q <= ST_OPC;
      end
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/dualbuf_spi_loader.sv
module dualbuf_spi_loader import dbl_pkg::*; #(
  parameter int unsigned BUF_BYTES   = 1056,
  parameter int unsigned ADDR_BYTES  = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  OP_A        = 8'h84,
  parameter logic [7:0]  OP_B        = 8'h87,
  localparam int unsigned ADDR_W     = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              buf_a_we_o,
  output logic              buf_b_we_o,
  output logic              buf_sel_o,
  output logic              mode3_o
);
  logic cs_s, sck_s, si_s;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_vld, rx_idle;

  dbl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));
  dbl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));
  dbl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(si_i), .q_o(si_s));

  dbl_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_s), .sck_i(sck_s), .si_i(si_s),
    .byte_o(rx_byte), .byte_vld_o(rx_vld), .idle_o(rx_idle), .mode3_o(mode3_o));

  dbl_cmd #(
    .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES),
    .OP_A(OP_A), .OP_B(OP_B)
  ) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(rx_byte), .byte_vld_i(rx_vld),
    .idle_i(rx_idle), .addr_o(buf_addr_o), .data_o(buf_data_o),
    .we_a_o(buf_a_we_o), .we_b_o(buf_b_we_o), .sel_o(buf_sel_o));
endmodule

// File: rtl/dualbuf_spi_loader_chk.sv
module dualbuf_spi_loader_chk #(
  parameter int unsigned BUF_BYTES = 1056,
  parameter int unsigned ADDR_W    = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] buf_addr_o,
  input logic              buf_a_we_o,
  input logic              buf_b_we_o,
  input logic              buf_sel_o
);
  AST_SINGLE_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_a_we_o && buf_b_we_o)); // R10
  AST_WE_A_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_a_we_o |=> !buf_a_we_o); // R10
  AST_WE_B_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_b_we_o |=> !buf_b_we_o); // R10
  AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_a_we_o || buf_b_we_o) |-> ({1'b0, buf_addr_o} < (ADDR_W+1)'(BUF_BYTES))); // R4
  AST_SEL_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_a_we_o |-> !buf_sel_o); // R1
  AST_SEL_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_b_we_o |-> buf_sel_o); // R1
endmodule

bind dualbuf_spi_loader dualbuf_spi_loader_chk #(
  .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .buf_addr_o(buf_addr_o),
  .buf_a_we_o(buf_a_we_o), .buf_b_we_o(buf_b_we_o), .buf_sel_o(buf_sel_o));

// File: tb/dualbuf_spi_loader_tb_top.sv
module dualbuf_spi_loader_tb_top;
  localparam int LEN = 1056;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic sck_i = 1'b1;
  logic si_i = 1'b0;
  logic [10:0] buf_addr_o;
  logic [7:0]  buf_data_o;
  logic buf_a_we_o, buf_b_we_o, buf_sel_o, mode3_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // packed record: [20]=we_b [19]=sel [18:8]=addr [7:0]=data
  logic [20:0] got_q[$];
  logic [20:0] exp_q[$];

  always #10 clk = ~clk;

  dualbuf_spi_loader dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .si_i(si_i),
    .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o), .buf_a_we_o(buf_a_we_o),
    .buf_b_we_o(buf_b_we_o), .buf_sel_o(buf_sel_o), .mode3_o(mode3_o));

  always @(negedge clk)
    if (buf_a_we_o || buf_b_we_o)
      got_q.push_back({buf_b_we_o, buf_sel_o, buf_addr_o, buf_data_o});

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 1'b0;
      si_i  = b[7-i];
      wait_clk(4);
      sck_i = 1'b1;
      wait_clk(4);
    end
  endtask

  task automatic cs_open(input bit m3, input string req);
    sck_i = m3;
    wait_clk(6);
    cs_ni = 1'b0;
    wait_clk(6);
    check(mode3_o == m3, req, mode3_o, m3);
  endtask

  task automatic cs_close(input bit m3);
    wait_clk(4);
    sck_i = m3;
    wait_clk(4);
    cs_ni = 1'b1;
    wait_clk(8);
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 13 + i * 29 + 5) & 8'hff);
  endfunction

  task automatic expect_run(input bit bsel, input logic [31:0] adr, input int n, input int seed);
    int pos = int'(adr[10:0]) % LEN;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({bsel, bsel, 11'(pos), pat(seed, i)});
      pos = (pos + 1) % LEN;
    end
  endtask

  task automatic send_cmd(input bit m3, input logic [7:0] op, input logic [31:0] adr,
                          input int n, input int seed);
    cs_open(m3, "R8");
    tx_bits(op, 8);
    for (int k = 3; k >= 0; k--) tx_bits(adr[k*8 +: 8], 8);
    for (int i = 0; i < n; i++) tx_bits(pat(seed, i), 8);
    cs_close(m3);
  endtask

  task automatic compare(input string req);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    wait_clk(5);
    // R9 / R8: reset state
    check(mode3_o == 1'b1, "R8 reset mode", mode3_o, 1);
    check(!buf_a_we_o && !buf_b_we_o, "R9 reset we", {buf_a_we_o, buf_b_we_o}, 0);
    rst_ni = 1'b1;
    wait_clk(4);
    check(mode3_o == 1'b1, "R8 mode after release", mode3_o, 1);

    // R1 R5 R8: buffer A in mode 0, buffer B in mode 3
    send_cmd(1'b0, 8'h84, 32'h0000_0005, 10, 1);
    expect_run(1'b0, 32'h5, 10, 1);
    compare("R1 R5 bufA mode0");
    check(mode3_o == 1'b0, "R8 mode0 held", mode3_o, 0);
    send_cmd(1'b1, 8'h87, 32'h0000_0010, 6, 2);
    expect_run(1'b1, 32'h10, 6, 2);
    compare("R1 R5 bufB mode3");

    // R4: wrap across the last position
    send_cmd(1'b1, 8'h87, 32'h0000_041A, 12, 3);
    expect_run(1'b1, 32'h41A, 12, 3);
    compare("R4 wrap bufB");
    send_cmd(1'b0, 8'h84, 32'h0000_041F, 3, 4);
    expect_run(1'b0, 32'h41F, 3, 4);
    compare("R4 wrap at last bufA");

    // R2 R3: upper bits ignored, out-of-range reduced
    send_cmd(1'b0, 8'h84, 32'hFFFF_FFFF, 3, 5);
    expect_run(1'b0, 32'h7FF, 3, 5);
    compare("R2 R3 all ones");
    send_cmd(1'b1, 8'h87, 32'hA5A5_F420, 2, 6);
    expect_run(1'b1, 32'h420, 2, 6);
    compare("R3 exactly 1056");

    // R2 R3 R4: sweep of start field across 0..2047
    for (int a = 0; a < 2048; a += 41) begin
      logic [31:0] adr = {21'(a * 7919 + 3), 11'(a)};
      bit b = a[0];
      send_cmd(a[1], b ? 8'h87 : 8'h84, adr, 2, a);
      expect_run(b, adr, 2, a);
      compare("R2 R3 R4 sweep");
    end

    // R7: unknown opcodes followed by opcode-like bytes
    cs_open(1'b0, "R8");
    tx_bits(8'h85, 8);
    for (int k = 0; k < 8; k++) tx_bits(8'h84, 8);
    cs_close(1'b0);
    cs_open(1'b1, "R8");
    tx_bits(8'h04, 8);
    for (int k = 0; k < 8; k++) tx_bits(8'h87, 8);
    cs_close(1'b1);
    compare("R7 unknown opcode");

    // R6: partial byte dropped, next command clean
    cs_open(1'b0, "R8");
    tx_bits(8'h84, 8);
    for (int k = 3; k >= 0; k--) tx_bits(8'(k == 0 ? 100 : 0), 8);
    for (int i = 0; i < 3; i++) tx_bits(pat(7, i), 8);
    tx_bits(8'hAA, 5);
    cs_close(1'b0);
    expect_run(1'b0, 32'd100, 3, 7);
    compare("R6 partial dropped");
    cs_open(1'b1, "R8");
    tx_bits(8'h87, 3);
    cs_close(1'b1);
    send_cmd(1'b1, 8'h87, 32'd100, 4, 8);
    expect_run(1'b1, 32'd100, 4, 8);
    compare("R6 fresh after partial");

    // R9: reset mid-command, select held low through release
    cs_open(1'b0, "R8");
    tx_bits(8'h84, 8);
    for (int k = 0; k < 4; k++) tx_bits(8'h00, 8);
    for (int i = 0; i < 2; i++) tx_bits(pat(9, i), 8);
    tx_bits(8'h33, 4);
    rst_ni = 1'b0;
    wait_clk(2);
    check(mode3_o == 1'b1, "R9 mode in reset", mode3_o, 1);
    check(!buf_a_we_o && !buf_b_we_o, "R9 we in reset", {buf_a_we_o, buf_b_we_o}, 0);
    rst_ni = 1'b1;
    wait_clk(4);
    tx_bits(8'h84, 8);
    for (int k = 0; k < 4; k++) tx_bits(8'h00, 8);
    for (int i = 0; i < 4; i++) tx_bits(8'h5A, 8);
    cs_close(1'b0);
    expect_run(1'b0, 32'd0, 2, 9);
    compare("R9 abort and rearm");
    send_cmd(1'b0, 8'h84, 32'd7, 3, 10);
    expect_run(1'b0, 32'd7, 3, 10);
    compare("R9 after rearm");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule